// File: doc/BRIEF.md
# I2C Monochrome Panel Frame Receiver

This block is the write side of a small graphics panel's bus interface. It is a target on a two-wire I2C bus that accepts write transactions from a host and places the pixel bytes in an on-chip frame store. The frame store holds a 128x64 one-bit-per-pixel image, which is 1024 bytes of eight pixels each. It also tracks which display line scanning starts from. The bus wires arrive as open-drain levels. They are synchronised to a fast system clock, and START, STOP and clock edges are found by comparing consecutive samples.

After its address, a transaction carries a control byte. The two upper bits of the control byte choose whether the bytes after it are commands or pixel data, and whether that choice holds for one byte or for the rest of the transaction. Pixel data goes to consecutive frame addresses from a pointer that restarts at zero on every transaction. After the last frame byte the pointer wraps to zero and keeps accepting data. The only command that is acted on is set-start-line, codes 0x40 to 0x7F. A read port on the system clock returns any frame byte and the current start line to the display scan logic.

Top module: `panel_i2c_sink`

## Requirements
- R1: While reset is held and right after it, the target leaves SDA released (`sda_oe` = 0) and the start line reads 0.
- R2: An address byte whose upper seven bits equal 0x3C and whose bit 0 (read/write) is 0 is acknowledged: `sda_oe` is 1 during the ninth clock. Any other address byte, including 0x3C with bit 0 set, gets no acknowledge. In that case the rest of the transaction changes neither the frame store nor the start line.
- R3: After a control byte with bit 7 = 0 and bit 6 = 1, every further byte of the transaction is acknowledged and stored at frame addresses 0, 1, 2 and so on, in arrival order.
- R4: The data pointer wraps after frame address 1023. Data byte number 1025 of one stream overwrites address 0, byte 1026 overwrites address 1, and addresses not reached again keep their first-pass values.
- R5: After a control byte with bit 7 = 0 and bit 6 = 0, each following byte is a command. A command from 0x40 to 0x7F sets the start line to its low six bits, so the range is 0 to 63.
- R6: Command bytes outside 0x40 to 0x7F, for example 0xAF or 0x20, are acknowledged but leave the start line unchanged.
- R7: A control byte with bit 7 = 1 applies to one following byte only. Bit 6 = 1 makes that byte data and bit 6 = 0 makes it a command. The byte after it is again decoded as a control byte.
- R8: A START, or a repeated START, resets the data pointer to 0, and the first byte after the address is decoded as a control byte. A STOP ends the stream.
- R9: The target changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge), 0 releases it |
| rd_addr | input | 10 | Frame byte address for the read port |
| rd_data | output | 8 | Frame byte at `rd_addr`, combinational read |
| start_line | output | 6 | Display line that scanning starts from |

## Verification
If the bit counter or the byte framing is wrong, the acknowledge appears in the wrong clock slot. The host sees this within the first byte after the address. If the control-byte state is wrong, a control byte is stored as a pixel or a pixel is taken as a command. That shows up as frame bytes shifted by one address, or as a start line that moves when no command was sent, once the transaction ends. A pointer that fails to wrap or to reset stays hidden until a long stream or a second transaction. The bench therefore drives one stream of 1026 bytes and also back-to-back transactions joined by a repeated START.

// File: rtl/panel_pkg.sv
package panel_pkg;

  localparam int BYTE_W = 8;
  localparam int LINE_W = 6;

  // byte receiver phases
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_BITS = 2'd1,
    RX_ACK  = 2'd2
  } rx_state_t;

  // payload decoding after the address byte
  typedef enum logic [2:0] {
    PL_CTRL     = 3'd0,
    PL_CMD_ONE  = 3'd1,
    PL_DATA_ONE = 3'd2,
    PL_CMD_RUN  = 3'd3,
    PL_DATA_RUN = 3'd4
  } pl_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] scl_pipe_q, scl_pipe_d;
  logic [PIPE_W-1:0] sda_pipe_q, sda_pipe_d;
  logic scl_now, scl_prev, sda_now, sda_prev;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[PIPE_W-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[PIPE_W-2:0], sda_i};
  end

  // idle bus level is high on both wires
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
    end
  end

  assign scl_now  = scl_pipe_q[PIPE_W-2];
  assign scl_prev = scl_pipe_q[PIPE_W-1];
  assign sda_now  = sda_pipe_q[PIPE_W-2];
  assign sda_prev = sda_pipe_q[PIPE_W-1];

  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign bus_start = scl_now & scl_prev & sda_prev & ~sda_now;
  assign bus_stop  = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import panel_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  output logic              sda_oe,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              rx_idle
);

  localparam logic [3:0] LAST_BIT  = 4'(BYTE_W - 1);
  localparam logic [3:0] BYTE_FULL = 4'(BYTE_W);

  rx_state_t         state_q, state_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              addr_ph_q, addr_ph_d;
  logic              oe_q, oe_d;
  logic [BYTE_W-1:0] full_byte;
  logic              addr_ok;

  assign full_byte = {sh_q[BYTE_W-2:0], sda_s};
  assign addr_ok   = (full_byte[BYTE_W-1:1] == TARGET_ADDR) && !full_byte[0];

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    addr_ph_d  = addr_ph_q;
    oe_d       = oe_q;
    byte_valid = 1'b0;
    if (bus_start) begin
      state_d   = RX_BITS;
      cnt_d     = '0;
      addr_ph_d = 1'b1;
      oe_d      = 1'b0;
    end else if (bus_stop) begin
      state_d = RX_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        RX_BITS: begin
          if (scl_rise && cnt_q < BYTE_FULL) begin
            sh_d  = full_byte;
            cnt_d = cnt_q + 4'd1;
            if (cnt_q == LAST_BIT) begin
              if (addr_ph_q) begin
                if (!addr_ok) state_d = RX_IDLE;
              end else begin
                byte_valid = 1'b1;
              end
            end
          end else if (scl_fall && cnt_q == BYTE_FULL) begin
            oe_d    = 1'b1;
            state_d = RX_ACK;
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            oe_d      = 1'b0;
            cnt_d     = '0;
            addr_ph_d = 1'b0;
            state_d   = RX_BITS;
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      addr_ph_q <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      addr_ph_q <= addr_ph_d;
      oe_q      <= oe_d;
    end
  end

  assign sda_oe    = oe_q;
  assign byte_data = full_byte;
  assign rx_idle   = (state_q == RX_IDLE);

endmodule

// File: rtl/payload_decode.sv
module payload_decode
  import panel_pkg::*;
#(
  parameter int FRAME_BYTES = 1024,
  localparam int PTR_W = $clog2(FRAME_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic              cmd_sel,
  output logic [LINE_W-1:0] start_line
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(FRAME_BYTES - 1);

  pl_state_t         st_q, st_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              is_data_st, is_cmd_st, line_cmd;

  assign is_data_st = (st_q == PL_DATA_ONE) || (st_q == PL_DATA_RUN);
  assign is_cmd_st  = (st_q == PL_CMD_ONE)  || (st_q == PL_CMD_RUN);
  assign wr_en      = byte_valid && is_data_st;
  assign line_cmd   = byte_valid && is_cmd_st && (byte_data[7:6] == 2'b01);

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    line_d = line_q;
    if (bus_start || bus_stop) begin
      st_d  = PL_CTRL;
      ptr_d = '0;
    end else if (byte_valid) begin
      case (st_q)
        PL_CTRL: begin
          case (byte_data[7:6])
            2'b00:   st_d = PL_CMD_RUN;
            2'b01:   st_d = PL_DATA_RUN;
            2'b10:   st_d = PL_CMD_ONE;
            default: st_d = PL_DATA_ONE;
          endcase
        end
        PL_CMD_ONE, PL_DATA_ONE: st_d = PL_CTRL;
        default: st_d = st_q;
      endcase
      if (wr_en) ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
      if (line_cmd) line_d = byte_data[LINE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PL_CTRL;
      ptr_q  <= '0;
      line_q <= '0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      line_q <= line_d;
    end
  end

  assign wr_ptr     = ptr_q;
  assign cmd_sel    = is_cmd_st;
  assign start_line = line_q;

endmodule

// File: rtl/frame_store.sv
module frame_store #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic [AW-1:0]    ra,
  output logic [WIDTH-1:0] rd
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd = mem[ra];

endmodule

// File: rtl/panel_i2c_sink.sv
module panel_i2c_sink
  import panel_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h3C,
  parameter int FRAME_BYTES = 1024,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W = $clog2(FRAME_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [LINE_W-1:0] start_line
);

  logic [1:0]        rst_pipe_q;
  logic              rst_ni;
  logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              byte_valid, rx_idle, wr_en, cmd_sel;
  logic [BYTE_W-1:0] byte_data;
  logic [PTR_W-1:0]  wr_ptr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_byte_rx #(.TARGET_ADDR(TARGET_ADDR)) u_rx (
    .clk(clk), .rst_n(rst_ni), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .sda_oe(sda_oe), .byte_valid(byte_valid), .byte_data(byte_data),
    .rx_idle(rx_idle)
  );

  payload_decode #(.FRAME_BYTES(FRAME_BYTES)) u_dec (
    .clk(clk), .rst_n(rst_ni), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_valid(byte_valid), .byte_data(byte_data), .wr_en(wr_en),
    .wr_ptr(wr_ptr), .cmd_sel(cmd_sel), .start_line(start_line)
  );

  frame_store #(.DEPTH(FRAME_BYTES), .WIDTH(BYTE_W)) u_mem (
    .clk(clk), .we(wr_en), .wa(wr_ptr), .wd(byte_data),
    .ra(rd_addr), .rd(rd_data)
  );

endmodule

// File: rtl/panel_i2c_sink_chk.sv
module panel_i2c_sink_chk
  import panel_pkg::*;
#(
  parameter int PTR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              rx_idle,
  input logic              byte_valid,
  input logic [BYTE_W-1:0] byte_data,
  input logic              cmd_sel,
  input logic              wr_en,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic [LINE_W-1:0] start_line
);

  localparam logic [PTR_W-1:0] PTR_TOP = '1;

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_idle |-> !sda_oe);

  p_line_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && cmd_sel && byte_data[7:6] == 2'b01)
      |=> start_line == $past(byte_data[LINE_W-1:0]));

  p_line_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && cmd_sel) |=> $stable(start_line));

  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ptr != PTR_TOP) |=> wr_ptr == $past(wr_ptr) + PTR_W'(1));

  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ptr == PTR_TOP) |=> wr_ptr == '0);

endmodule

bind panel_i2c_sink panel_i2c_sink_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_ni), .scl_i(scl_i), .sda_oe(sda_oe),
  .rx_idle(rx_idle), .byte_valid(byte_valid), .byte_data(byte_data),
  .cmd_sel(cmd_sel), .wr_en(wr_en), .wr_ptr(wr_ptr), .start_line(start_line)
);

// File: tb/sim_panel_i2c_sink.sv
module sim_panel_i2c_sink;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam int DEPTH = 1024;
  localparam logic [7:0] WR_ADDR = 8'h78;

  logic       clk, rst_n, scl_m, sda_m, sda_oe;
  logic [9:0] rd_addr;
  logic [7:0] rd_data;
  logic [5:0] start_line;
  logic       sda_bus;

  int checks = 0;
  int fails = 0;
  int bptr = 0;
  logic [7:0] model [DEPTH];
  int exp_q[$];

  assign sda_bus = sda_m & ~sda_oe;

  panel_i2c_sink u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data),
    .start_line(start_line)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack_low);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qwait();
      scl_m = 1'b1; qwait(); qwait();
      scl_m = 1'b0;
    end
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    ack_low = ~sda_bus; qwait();
    scl_m = 1'b0; qwait();
  endtask

  // byte that must be acknowledged
  task automatic send_acked(input logic [7:0] b, input string req);
    logic a;
    put_byte(b, a);
    chk(req, a, 1);
  endtask

  // driver: stream pixel byte and record expectation in the scoreboard
  task automatic send_pixel(input logic [7:0] b, input string req);
    send_acked(b, req);
    model[bptr] = b;
    exp_q.push_back(bptr);
    bptr = (bptr + 1) % DEPTH;
  endtask

  // monitor: pop expected frame entries and compare through the read port
  task automatic drain(input string req);
    while (exp_q.size() > 0) begin
      int a;
      a = exp_q.pop_front();
      rd_addr = 10'(a);
      @(negedge clk);
      chk(req, rd_data, model[a]);
    end
  endtask

  task automatic peek(input int a, input int exp, input string req);
    rd_addr = 10'(a);
    @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    scl_m = 1'b1; sda_m = 1'b1; rd_addr = '0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 start line", start_line, 0);
    chk("R1 oe after reset", sda_oe, 0);

    // R3 data stream from address 0
    bus_start(); bptr = 0;
    send_acked(WR_ADDR, "R2 address ack");
    send_acked(8'h40, "R3 control ack");
    for (int i = 0; i < 8; i++) send_pixel(8'(8'h11 * (i + 1)), "R3 data ack");
    bus_stop();
    drain("R3 stored");

    // R5/R6 command stream
    bus_start();
    send_acked(WR_ADDR, "R2 address ack");
    send_acked(8'h00, "R5 control ack");
    send_acked(8'h4A, "R5 cmd ack");
    chk("R5 line 10", start_line, 10);
    send_acked(8'hAF, "R6 cmd ack");
    send_acked(8'h20, "R6 cmd ack");
    chk("R6 line held", start_line, 10);
    send_acked(8'h7F, "R5 cmd ack");
    chk("R5 line 63", start_line, 63);
    bus_stop();

    // R2 wrong address, then read direction
    bus_start();
    put_byte(8'h7A, a); chk("R2 wrong addr nack", a, 0);
    put_byte(8'h40, a); chk("R2 no ack after mismatch", a, 0);
    put_byte(8'hEE, a);
    bus_stop();
    peek(0, 8'h11, "R2 frame untouched");
    bus_start();
    put_byte(8'h79, a); chk("R2 read nack", a, 0);
    put_byte(8'h00, a);
    put_byte(8'h50, a);
    bus_stop();
    chk("R2 line untouched", start_line, 63);

    // R7 single-byte control, R8 pointer restarts
    bus_start(); bptr = 0;
    send_acked(WR_ADDR, "R2 address ack");
    send_acked(8'h80, "R7 ctrl ack");
    send_acked(8'h45, "R7 cmd ack");
    chk("R7 one command", start_line, 5);
    send_acked(8'hC0, "R7 ctrl ack");
    send_pixel(8'hA5, "R7 one data");
    send_acked(8'h40, "R7 ctrl again");
    send_pixel(8'h5A, "R7 data run");
    send_pixel(8'h3C, "R7 data run");
    bus_stop();
    drain("R7 R8 stored");
    chk("R7 line kept", start_line, 5);

    // R8 repeated START
    bus_start(); bptr = 0;
    send_acked(WR_ADDR, "R2 address ack");
    send_acked(8'h40, "R8 ctrl ack");
    send_pixel(8'h01, "R8 data");
    send_pixel(8'h02, "R8 data");
    bus_start(); bptr = 0;
    send_acked(WR_ADDR, "R8 address after restart");
    send_acked(8'h40, "R8 ctrl after restart");
    send_pixel(8'h99, "R8 data after restart");
    bus_stop();
    drain("R8 stored");
    peek(2, 8'h3C, "R8 control not stored");

    // R4 wrap: 1026 bytes in one stream
    bus_start(); bptr = 0;
    send_acked(WR_ADDR, "R2 address ack");
    send_acked(8'h40, "R4 ctrl ack");
    for (int i = 0; i < DEPTH + 2; i++) send_pixel(8'((i * 7 + 3) & 8'hFF), "R4 data ack");
    bus_stop();
    drain("R4 wrapped frame");
    peek(0, 8'((DEPTH * 7 + 3) & 8'hFF), "R4 addr0 overwritten");
    peek(2, 8'h11, "R4 addr2 first pass");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule